// File: doc/BRIEF.md
# Two-Wire Control Bus Snooping Router

This block sits between a host that drives a two-wire control bus (clock line and data line) and two downstream bus segments: a configuration-memory segment and a display-data-channel segment. A third destination, a small register stub inside the block, is also reachable. The router oversamples the host lines with a fast system clock, recognises START, STOP and byte framing, and decides which downstream segment sees the host's lines. Segments that are not selected have both lines released high.

Out of reset the host's traffic passes through to the memory segment while the router listens. A transaction whose address byte carries the router's own address takes the route to the register stub, and the router acknowledges it. While on the stub, a write to the command register picks the next segment, and the switch happens at the STOP that closes that write. While on the display channel the router ignores address bytes and comes back to the stub at the first STOP that follows a START. Route changes happen only at a byte boundary or at a STOP, never mid-byte.

Top module: `ctl_bus_router`

## Requirements
- R1: After reset the memory segment follows the host lines, the display segment is released high and `host_sda_pull` is 0.
- R2: The router's 7-bit address is 0111000 with its lowest bit replaced by the inverse of `addr_sel`. The full address byte for a write is therefore 72h when `addr_sel` is 0 and 70h when it is 1. An address byte with any other address is not claimed.
- R3: On the memory route, an address byte (the first byte after a START, MSB first, bit 0 = read when 1) that carries the own address moves the route to the register stub once its eighth bit has been sampled. From the acknowledge slot of that byte onward, both memory lines are released high.
- R4: `host_sda_pull` is 1 during the ninth clock of the own-address byte and during the ninth clock of every following byte of a write. It stays 0 for every byte of a transaction to any other address.
- R5: In a write to the own address, the byte after the address byte sets a register pointer. Each later byte goes to the pointed register, and the pointer then increments. The command register sits at index 08h. A value whose low two bits are 01 selects the memory segment and 10 selects the display segment; 00 and 11 leave the route unchanged.
- R6: A command selected through R5 takes effect only at the STOP that ends the transaction. Before that STOP the route stays on the register stub.
- R7: On the display route, address bytes are not decoded or acknowledged (even the own address). A STOP that follows a START returns the route to the register stub.
- R8: The selected segment's clock and data outputs equal the host clock and data lines. Both lines of every unselected segment are 1.
- R9: START is data falling while clock is high, and STOP is data rising while clock is high. A START in the middle of a byte (repeated START) restarts byte framing, so the next byte is treated as an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 1 | Address select; picks the low bit of the own address |
| host_scl | input | 1 | Host bus clock line level |
| host_sda | input | 1 | Host bus data line level |
| host_sda_pull | output | 1 | 1 pulls the host data line low (acknowledge) |
| mem_scl | output | 1 | Memory segment clock line |
| mem_sda | output | 1 | Memory segment data line |
| ddc_scl | output | 1 | Display channel segment clock line |
| ddc_sda | output | 1 | Display channel segment data line |

## Verification
A wrong route state shows at once: as soon as the host pulls its clock low, the wrong segment's clock follows it, or a segment that should follow stays high. A wrong bit counter or address match shows within one byte, as a missing or extra acknowledge pull in the ninth clock. A command latched too early shows as the display segment following the host before the closing STOP. A missed START-before-STOP on the display route leaves the display segment still following the host after that STOP.

// File: rtl/busrt_pkg.sv
// Shared types for the control bus router.
// Assumes: route encoding is private to this block.
package busrt_pkg;
    typedef enum logic [1:0] {
        RT_MEM = 2'd0,
        RT_INT = 2'd1,
        RT_DDC = 2'd2
    } route_t;

    localparam logic [1:0] CMD_TO_MEM = 2'b01;
    localparam logic [1:0] CMD_TO_DDC = 2'b10;
endpackage

// File: rtl/busrt_edge_detect.sv
// Synchronises the host clock and data lines into the system clock domain
// and flags START, STOP and clock edges.
// Assumes: system clock is several times faster than the bus clock;
// idle level of both lines is high.
module busrt_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_q,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;
    logic              scl_q;

    assign raw = {scl_in, sda_in};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] chain;
            // Shift the raw line through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Keep last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_q     = synced[1];
    assign sda_q     = synced[0];
    assign start_evt = prev[1] & scl_q & prev[0] & ~sda_q;
    assign stop_evt  = prev[1] & scl_q & ~prev[0] & sda_q;
    assign scl_rise  = ~prev[1] & scl_q;
    assign scl_fall  = prev[1] & ~scl_q;

    // R9
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !stop_evt);
endmodule

// File: rtl/busrt_byte_track.sv
// Frames the host bit stream into bytes: counts clock rises, shifts data,
// marks the acknowledge slot and counts bytes since the last START.
// Assumes: START/STOP pulses from busrt_edge_detect.
module busrt_byte_track #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_q,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_q,
    output logic [1:0]        byte_idx,
    output logic              in_ack
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_CNT   = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] END_CNT   = CNT_W'(BYTE_W + 1);

    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;

    // Bit counter, shifter, acknowledge window and byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            shreg     <= '0;
            byte_q    <= '0;
            byte_done <= 1'b0;
            byte_idx  <= 2'd0;
            in_ack    <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start_evt || stop_evt) begin
                bitcnt   <= '0;
                byte_idx <= 2'd0;
                in_ack   <= 1'b0;
            end else if (scl_rise) begin
                if (bitcnt < ACK_CNT) shreg <= {shreg[BYTE_W-2:0], sda_q};
                if (bitcnt == LAST_DATA) begin
                    byte_done <= 1'b1;
                    byte_q    <= {shreg[BYTE_W-2:0], sda_q};
                end
                if (bitcnt < END_CNT) bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
                if (bitcnt == ACK_CNT) in_ack <= 1'b1;
                if (bitcnt == END_CNT) begin
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                    if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
                end
            end
        end
    end

    // R9
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= END_CNT);
    // R4
    ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ack |-> (bitcnt >= ACK_CNT));
endmodule

// File: rtl/busrt_route_ctrl.sv
// Route state machine plus register stub: snoops address bytes, claims the
// own address, decodes the command register and moves the route.
// Assumes: byte framing from busrt_byte_track; changes made only at byte
// boundaries or STOP.
module busrt_route_ctrl
    import busrt_pkg::*;
#(
    parameter logic [5:0] OWN_HI  = 6'b011100,
    parameter logic [7:0] CMD_IDX = 8'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_sel,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       byte_done,
    input  logic [7:0] byte_q,
    input  logic [1:0] byte_idx,
    input  logic       in_ack,
    output route_t     route,
    output logic       sda_pull
);
    logic [6:0] own_addr;
    logic       addr_hit;
    logic       addressed;
    logic       rw_rd;
    logic [7:0] reg_ptr;
    logic       pend_valid;
    route_t     pend_route;
    logic       ddc_seen_start;

    assign own_addr = {OWN_HI, ~addr_sel};
    assign addr_hit = (byte_q[7:1] == own_addr);

    // Route, claim, pointer and pending command update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route          <= RT_MEM;
            addressed      <= 1'b0;
            rw_rd          <= 1'b0;
            reg_ptr        <= '0;
            pend_valid     <= 1'b0;
            pend_route     <= RT_INT;
            ddc_seen_start <= 1'b0;
        end else begin
            if (start_evt) begin
                addressed <= 1'b0;
                if (route == RT_DDC) ddc_seen_start <= 1'b1;
            end
            if (stop_evt) begin
                addressed <= 1'b0;
                if (route == RT_INT && pend_valid) begin
                    route      <= pend_route;
                    pend_valid <= 1'b0;
                end
                if (route == RT_DDC && ddc_seen_start) begin
                    route          <= RT_INT;
                    ddc_seen_start <= 1'b0;
                end
            end
            if (byte_done) begin
                unique case (route)
                    RT_MEM: begin
                        if (byte_idx == 2'd0 && addr_hit) begin
                            route     <= RT_INT;
                            addressed <= 1'b1;
                            rw_rd     <= byte_q[0];
                        end
                    end
                    RT_INT: begin
                        if (byte_idx == 2'd0) begin
                            addressed <= addr_hit;
                            rw_rd     <= byte_q[0];
                        end else if (addressed && !rw_rd) begin
                            if (byte_idx == 2'd1) begin
                                reg_ptr <= byte_q;
                            end else begin
                                if (reg_ptr == CMD_IDX) begin
                                    if (byte_q[1:0] == CMD_TO_MEM) begin
                                        pend_valid <= 1'b1;
                                        pend_route <= RT_MEM;
                                    end else if (byte_q[1:0] == CMD_TO_DDC) begin
                                        pend_valid <= 1'b1;
                                        pend_route <= RT_DDC;
                                    end
                                end
                                reg_ptr <= reg_ptr + 8'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = addressed && in_ack && (byte_idx == 2'd0 || !rw_rd);

    // R3
    mem_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(route) == RT_MEM && route != RT_MEM) |-> (route == RT_INT && $past(byte_done)));
    // R6
    int_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(route) == RT_INT && route != RT_INT) |-> $past(stop_evt));
    // R7
    ddc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(route) == RT_DDC && route != RT_DDC) |-> (route == RT_INT && $past(stop_evt)));
    // R4
    pull_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (route == RT_INT));
endmodule

// File: rtl/ctl_bus_router.sv
// Top of the two-wire control bus router: edge detection, byte framing,
// route control and the downstream line multiplexing.
// Assumes: host lines are plain logic levels; open-drain pads sit outside.
module ctl_bus_router
    import busrt_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] OWN_HI      = 6'b011100,
    parameter logic [7:0] CMD_IDX     = 8'h08
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_sel,
    input  logic host_scl,
    input  logic host_sda,
    output logic host_sda_pull,
    output logic mem_scl,
    output logic mem_sda,
    output logic ddc_scl,
    output logic ddc_sda
);
    logic       sda_q, start_evt, stop_evt, scl_rise, scl_fall;
    logic       byte_done, in_ack;
    logic [7:0] byte_q;
    logic [1:0] byte_idx;
    route_t     route;

    busrt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .scl_in(host_scl), .sda_in(host_sda),
        .sda_q(sda_q), .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    busrt_byte_track #(.BYTE_W(8)) u_track (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_q(sda_q),
        .byte_done(byte_done), .byte_q(byte_q), .byte_idx(byte_idx),
        .in_ack(in_ack)
    );

    busrt_route_ctrl #(.OWN_HI(OWN_HI), .CMD_IDX(CMD_IDX)) u_route (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .start_evt(start_evt), .stop_evt(stop_evt), .byte_done(byte_done),
        .byte_q(byte_q), .byte_idx(byte_idx), .in_ack(in_ack),
        .route(route), .sda_pull(host_sda_pull)
    );

    // Selected segment follows the host; others are released high.
    assign mem_scl = (route == RT_MEM) ? host_scl : 1'b1;
    assign mem_sda = (route == RT_MEM) ? host_sda : 1'b1;
    assign ddc_scl = (route == RT_DDC) ? host_scl : 1'b1;
    assign ddc_sda = (route == RT_DDC) ? host_sda : 1'b1;

    // R8
    one_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_scl && !ddc_scl));
endmodule

// File: tb/ctl_bus_router_bench.sv
module ctl_bus_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic host_sda_line;
    logic host_sda_pull, mem_scl, mem_sda, ddc_scl, ddc_sda;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    assign host_sda_line = sda_drv & ~host_sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_bus_router u_ctl_bus_router (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .host_scl(scl_drv), .host_sda(host_sda_line),
        .host_sda_pull(host_sda_pull),
        .mem_scl(mem_scl), .mem_sda(mem_sda),
        .ddc_scl(ddc_scl), .ddc_sda(ddc_sda)
    );

    // {addr, index, data, expected ack, expected route 0=mem 1=int 2=ddc}
    localparam logic [26:0] VEC [0:8] = '{
        {8'hA0, 8'h00, 8'h11, 1'b0, 2'd0},
        {8'h72, 8'h05, 8'h02, 1'b1, 2'd1},
        {8'h72, 8'h08, 8'h02, 1'b1, 2'd2},
        {8'hA0, 8'h08, 8'h01, 1'b0, 2'd1},
        {8'h72, 8'h08, 8'h01, 1'b1, 2'd0},
        {8'h70, 8'h08, 8'h02, 1'b0, 2'd0},
        {8'h72, 8'h08, 8'h03, 1'b1, 2'd1},
        {8'h72, 8'h08, 8'h00, 1'b1, 2'd1},
        {8'h72, 8'h08, 8'h01, 1'b1, 2'd0}
    };

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; ticks(Q);
        scl_drv = 1'b1; ticks(2*Q);
        sda_drv = 1'b0; ticks(2*Q);
        scl_drv = 1'b0; ticks(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; ticks(Q);
        scl_drv = 1'b1; ticks(2*Q);
        sda_drv = 1'b1; ticks(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b;    ticks(Q);
        scl_drv = 1'b1; ticks(2*Q);
        scl_drv = 1'b0; ticks(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_drv = 1'b1; ticks(Q);
        scl_drv = 1'b1; ticks(Q);
        ack = host_sda_pull;
        ticks(Q);
        scl_drv = 1'b0; ticks(Q);
    endtask

    task automatic write3(input logic [7:0] a, input logic [7:0] i, input logic [7:0] d);
        logic k;
        bus_start();
        send_byte(a, k);
        send_byte(i, k);
        send_byte(d, k);
        bus_stop();
    endtask

    // Pull host lines low one at a time (bus idle) and see which segment follows.
    task automatic probe(input int exp, input string tag);
        scl_drv = 1'b0; ticks(1);
        chk(mem_scl == (exp != 0), {tag, " R8 mem_scl"}, mem_scl, exp != 0);
        chk(ddc_scl == (exp != 2), {tag, " R8 ddc_scl"}, ddc_scl, exp != 2);
        sda_drv = 1'b0; ticks(1);
        chk(mem_sda == (exp != 0), {tag, " R8 mem_sda"}, mem_sda, exp != 0);
        chk(ddc_sda == (exp != 2), {tag, " R8 ddc_sda"}, ddc_sda, exp != 2);
        sda_drv = 1'b1; ticks(1);
        scl_drv = 1'b1; ticks(Q);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a1, a2, a3;
        ticks(4);
        rst_n = 1'b1;
        ticks(4);

        // R1: reset state
        chk(host_sda_pull == 1'b0, "R1 pull after reset", host_sda_pull, 0);
        probe(0, "R1 reset route");

        // Vector table: R3 R4 R5 R7 across routes
        for (int v = 0; v < 9; v++) begin
            bus_start();
            send_byte(VEC[v][26:19], a1);
            send_byte(VEC[v][18:11], a2);
            send_byte(VEC[v][10:3], a3);
            bus_stop();
            chk({a1, a2, a3} == {3{VEC[v][2]}}, "R4 ack pattern", {a1, a2, a3}, {3{VEC[v][2]}});
            probe(int'(VEC[v][1:0]), "R3 R5 R7 route after vector");
        end

        // R6: command does not act before STOP
        bus_start();
        send_byte(8'h72, a1);
        send_byte(8'h08, a2);
        send_byte(8'h02, a3);
        chk(ddc_scl == 1'b1, "R6 ddc before stop", ddc_scl, 1);
        chk(mem_scl == 1'b1, "R6 mem before stop", mem_scl, 1);
        bus_stop();
        probe(2, "R6 route after stop");

        // R7: own address not claimed on display route, START+STOP returns
        bus_start();
        send_byte(8'h72, a1);
        chk(a1 == 1'b0, "R7 no ack on display route", a1, 0);
        chk(ddc_scl == 1'b0, "R7 display still follows", ddc_scl, 0);
        bus_stop();
        probe(1, "R7 back to stub");

        // R5: pointer auto-increment reaches the command register
        bus_start();
        send_byte(8'h72, a1);
        send_byte(8'h07, a2);
        send_byte(8'h00, a3);
        send_byte(8'h02, a3);
        bus_stop();
        probe(2, "R5 auto-increment command");
        bus_start();
        bus_stop();
        probe(1, "R7 bare start stop");

        // R9: repeated START mid-byte reframes; R3 memory released at ack
        write3(8'h72, 8'h08, 8'h01);
        probe(0, "R9 setup memory route");
        bus_start();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        sda_drv = 1'b1; ticks(Q);
        scl_drv = 1'b1; ticks(2*Q);
        sda_drv = 1'b0; ticks(2*Q);
        scl_drv = 1'b0; ticks(Q);
        send_byte(8'h72, a1);
        chk(a1 == 1'b1, "R9 ack after repeated start", a1, 1);
        chk(mem_scl == 1'b1, "R3 memory released", mem_scl, 1);
        bus_stop();
        probe(1, "R9 route after claim");

        // R2: address select moves the own address
        write3(8'h72, 8'h08, 8'h01);
        addr_sel = 1'b1;
        ticks(Q);
        bus_start();
        send_byte(8'h72, a1);
        chk(a1 == 1'b0, "R2 72h not claimed with select high", a1, 0);
        bus_stop();
        probe(0, "R2 stays memory");
        bus_start();
        send_byte(8'h70, a1);
        chk(a1 == 1'b1, "R2 70h claimed with select high", a1, 1);
        bus_stop();
        probe(1, "R2 route to stub");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule